// File: doc/BRIEF.md
# Sensor Frequency Count Serializer

This block turns the frequency of a sensor-controlled oscillator into a serial character for a radio link. During a gate window, it counts the rising edges of the sensor clock into a saturating counter. When the window closes, the count goes into a framing shift register and the counter restarts from zero. The captured value then leaves on a single transmit line as one character: a start bit, eight data bits with the least significant first, and a stop bit. The line advances by one bit per period of a separate shift clock.

All four asynchronous inputs are brought into the system clock domain through synchronisers. These are the sensor clock, the gate clock, the shift clock and the link's clear-to-send level. The block therefore runs on a single clock. A request-to-send output is high from the moment a count is captured until its stop bit has been on the line for a full bit period. Transmission of a captured frame waits for clear-to-send. A window that closes while a frame is still pending or in flight is dropped. A sticky flag records that some window saw more edges than the counter can hold.

Top module: `sensor_freq_serializer`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `txd_o` is 1 and `rts_o` and `ovf_o` are 0. Asserting `rst_n` during a frame abandons that frame.
- R2: A captured count equals the number of rising edges of `sens_clk_i` seen while `gate_clk_i` is high. Edges while the gate is low have no effect on the count.
- R3: The count stops at 255 and does not wrap. A sensor edge that arrives while the count is 255 sets `ovf_o`, which stays 1 until reset.
- R4: A falling edge of `gate_clk_i` ends the window. The counter then restarts from zero for the next window.
- R5: A frame on `txd_o` is a start bit of 0, then the eight count bits with bit 0 first, then a stop bit of 1. `txd_o` moves to the next bit only on a rising edge of `shift_clk_i`.
- R6: `rts_o` rises when a count is captured. It falls at the first rising edge of `shift_clk_i` after the stop bit was put on the line.
- R7: After a capture, `txd_o` stays 1 until a rising edge of `shift_clk_i` finds `cts_i` high. That edge puts the start bit on the line.
- R8: Once the start bit is on the line, the frame runs to its stop bit whatever `cts_i` does.
- R9: A window that ends while `rts_o` is high is not captured and its count is lost. The frame in progress is unaffected.
- R10: `txd_o` is 1 whenever `rts_o` is 0.
- R11: Each input passes through a two-stage synchroniser. A change sampled at one rising edge of `clk` acts on the state at the second edge after it, and so becomes visible on the outputs after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sens_clk_i | input | 1 | Oscillator clock whose frequency depends on the sensor |
| gate_clk_i | input | 1 | Slow clock; its high phase is the counting window |
| shift_clk_i | input | 1 | Bit-rate clock for the serial line |
| cts_i | input | 1 | Clear-to-send level from the link |
| txd_o | output | 1 | Serial transmit line, idle high |
| rts_o | output | 1 | Request-to-send, high while a frame is pending or being sent |
| ovf_o | output | 1 | Sticky flag: a window exceeded the counter range |

## Verification
The checker assumes that every high and low phase of the three input clocks lasts at least one system clock. With that, the synchronisers see each level and no edge is lost. It also assumes that `cts_i` is a level that holds for at least one system clock. The stimulus drives the sensor clock two cycles high and two low, the shift clock four and four, and the gate for hundreds of cycles. All input changes are placed one time unit after a falling edge of `clk`. The cycle model in the bench takes the same assumptions. It compares the three outputs on every cycle and decodes each character from `txd_o` against the number of pulses the stimulus produced.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_WAIT = 2'd1,
      TX_SEND = 2'd2
   } tx_state_e;
endpackage

// File: rtl/fcs_sync_chain.sv
module fcs_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fcs_sync_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '0;
      else        ff <= {ff[STAGES-2:0], d_i};
   end

   assign q_o = ff[STAGES-1];
endmodule

// File: rtl/fcs_input_cond.sv
module fcs_input_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sens_i,
   input  logic gate_i,
   input  logic shift_i,
   input  logic cts_i,
   output logic sens_rise_o,
   output logic gate_lvl_o,
   output logic gate_fall_o,
   output logic shift_rise_o,
   output logic cts_lvl_o
);
   localparam int NCH   = 4;
   localparam int N_EDG = 3;

   logic [NCH-1:0]   raw;
   logic [NCH-1:0]   synced;
   logic [N_EDG-1:0] prev;

   assign raw = {cts_i, shift_i, gate_i, sens_i};

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      fcs_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (raw[ch]),
         .q_o   (synced[ch])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= synced[N_EDG-1:0];
   end

   assign sens_rise_o  =  synced[0] & ~prev[0];
   assign gate_lvl_o   =  synced[1];
   assign gate_fall_o  = ~synced[1] &  prev[1];
   assign shift_rise_o =  synced[2] & ~prev[2];
   assign cts_lvl_o    =  synced[3];
endmodule

// File: rtl/fcs_sat_counter.sv
module fcs_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o,
   output logic         ovf_o
);
   if (W < 1) begin : g_bad_w
      $error("fcs_sat_counter: W must be at least 1");
   end

   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
         ovf_o <= 1'b0;
      end else if (clr_i) begin
         cnt_o <= '0;
      end else if (inc_i) begin
         if (cnt_o == TOP) ovf_o <= 1'b1;
         else              cnt_o <= cnt_o + W'(1);
      end
   end
endmodule

// File: rtl/fcs_frame_tx.sv
module fcs_frame_tx
   import fcs_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              tick_i,
   input  logic              cts_i,
   output logic              txd_o,
   output logic              busy_o,
   output logic              sending_o
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam logic [BIT_W-1:0]   LAST_BIT = BIT_W'(FRAME_W - 1);
   localparam logic [FRAME_W-1:0] IDLE_PAT = {{(FRAME_W-1){1'b0}}, 1'b1};

   if (DATA_W < 1) begin : g_bad_dw
      $error("fcs_frame_tx: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0]  ordered;
   logic [FRAME_W-1:0] frame;
   logic [BIT_W-1:0]   bitn;
   tx_state_e          st;

   for (genvar i = 0; i < DATA_W; i++) begin : g_ord
      if (LSB_FIRST) begin : g_lsb
         assign ordered[DATA_W-1-i] = data_i[i];
      end else begin : g_msb
         assign ordered[i] = data_i[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= TX_IDLE;
         frame <= IDLE_PAT;
         bitn  <= '0;
      end else begin
         case (st)
            TX_IDLE: if (load_i) begin
               frame <= {1'b0, ordered, 1'b1};
               bitn  <= '0;
               st    <= TX_WAIT;
            end
            TX_WAIT: if (tick_i && cts_i) st <= TX_SEND;
            TX_SEND: if (tick_i) begin
               if (bitn == LAST_BIT) begin
                  st    <= TX_IDLE;
                  frame <= IDLE_PAT;
               end else begin
                  frame <= {frame[FRAME_W-2:0], 1'b0};
                  bitn  <= bitn + BIT_W'(1);
               end
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   assign sending_o = (st == TX_SEND);
   assign busy_o    = (st != TX_IDLE);
   assign txd_o     = sending_o ? frame[FRAME_W-1] : 1'b1;
endmodule

// File: rtl/sensor_freq_serializer.sv
module sensor_freq_serializer #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LSB_FIRST   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sens_clk_i,
   input  logic gate_clk_i,
   input  logic shift_clk_i,
   input  logic cts_i,
   output logic txd_o,
   output logic rts_o,
   output logic ovf_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("sensor_freq_serializer: CNT_W must be at least 1");
   end

   logic             sens_rise_w;
   logic             gate_lvl_w;
   logic             win_end_w;
   logic             shift_rise_w;
   logic             cts_lvl_w;
   logic             sending_w;
   logic [CNT_W-1:0] cnt_w;

   fcs_input_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk          (clk),
      .rst_n        (rst_n),
      .sens_i       (sens_clk_i),
      .gate_i       (gate_clk_i),
      .shift_i      (shift_clk_i),
      .cts_i        (cts_i),
      .sens_rise_o  (sens_rise_w),
      .gate_lvl_o   (gate_lvl_w),
      .gate_fall_o  (win_end_w),
      .shift_rise_o (shift_rise_w),
      .cts_lvl_o    (cts_lvl_w)
   );

   fcs_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (gate_lvl_w & sens_rise_w),
      .clr_i (win_end_w),
      .cnt_o (cnt_w),
      .ovf_o (ovf_o)
   );

   fcs_frame_tx #(.DATA_W(CNT_W), .LSB_FIRST(LSB_FIRST)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (win_end_w),
      .data_i    (cnt_w),
      .tick_i    (shift_rise_w),
      .cts_i     (cts_lvl_w),
      .txd_o     (txd_o),
      .busy_o    (rts_o),
      .sending_o (sending_w)
   );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             txd,
   input logic             rts,
   input logic             ovf,
   input logic [CNT_W-1:0] cnt,
   input logic             win_end,
   input logic             cts_lvl,
   input logic             sending
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !rts |-> txd); // R10
   AST_WAIT_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (rts && !sending) |-> txd); // R7
   AST_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n) (rts && !sending && !cts_lvl) |=> !sending); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf); // R3
   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cnt == TOP && !win_end) |=> cnt == TOP); // R3
   AST_OVF_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf) |-> $past(cnt) == TOP); // R3
   AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n) win_end |=> cnt == '0); // R4
   AST_STOP_LAST: assert property (@(posedge clk) disable iff (!rst_n) $fell(rts) |-> $past(txd)); // R5
endmodule

bind sensor_freq_serializer fcs_checker #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .txd     (txd_o),
   .rts     (rts_o),
   .ovf     (ovf_o),
   .cnt     (cnt_w),
   .win_end (win_end_w),
   .cts_lvl (cts_lvl_w),
   .sending (sending_w)
);

// File: tb/sim_sensor_freq_serializer.sv
`timescale 1ns/1ps
module sim_sensor_freq_serializer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sens = 1'b0, gate = 1'b0, shclk = 1'b0, cts = 1'b0;
   logic txd, rts, ovf;

   int n_chk = 0, n_fail = 0, cyc = 0, sh_div = 0, rts_rises = 0;
   bit done = 1'b0;
   logic rts_d = 1'b0;

   always #5 clk = ~clk;

   sensor_freq_serializer u0 (
      .clk(clk), .rst_n(rst_n), .sens_clk_i(sens), .gate_clk_i(gate),
      .shift_clk_i(shclk), .cts_i(cts), .txd_o(txd), .rts_o(rts), .ovf_o(ovf)
   );

   // behavioural reference: input histories, a count, a queue of frame bits
   bit s1, s2, s3, g1, g2, g3, k1, k2, k3, c1, c2;
   int m_cnt = 0, m_st = 0;   // 0 idle, 1 waiting for clear-to-send, 2 sending
   bit m_ovf = 0, m_cur = 1, m_adv = 0;
   bit m_q[$];
   bit rx[$];
   int exp_q[$];
   string tag_q[$];

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {s1, s2, s3, g1, g2, g3, k1, k2, k3, c1, c2} = '0;
         m_cnt = 0; m_st = 0; m_ovf = 0; m_cur = 1; m_adv = 0;
         m_q.delete(); rx.delete();
      end else begin
         int old_st;
         old_st = m_st;
         m_adv = 0;
         // R7 R8 R5 R6: start gated by clear-to-send, then one bit per shift edge
         if (old_st == 1 && (k2 && !k3) && c2) begin
            m_st = 2; m_cur = m_q.pop_front(); m_adv = 1;
         end else if (old_st == 2 && (k2 && !k3)) begin
            if (m_q.size() == 0) m_st = 0;
            else begin m_cur = m_q.pop_front(); m_adv = 1; end
         end
         // R4 R9 window end, R2 R3 counting
         if (!g2 && g3) begin
            if (old_st == 0) begin
               m_q.delete();
               m_q.push_back(1'b0);
               for (int i = 0; i < 8; i++) m_q.push_back(bit'((m_cnt >> i) & 1));
               m_q.push_back(1'b1);
               m_st = 1;
            end
            m_cnt = 0;
         end else if (g2 && s2 && !s3) begin
            if (m_cnt == 255) m_ovf = 1;
            else m_cnt++;
         end
         // R11 two-stage synchroniser plus edge register
         s3 = s2; s2 = s1; s1 = sens;
         g3 = g2; g2 = g1; g1 = gate;
         k3 = k2; k2 = k1; k1 = shclk;
         c2 = c1; c1 = cts;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         chk(txd === ((m_st == 2) ? m_cur : 1'b1), (m_st == 2) ? "R5/R11" : "R10/R7", "txd", txd, (m_st == 2) ? m_cur : 1);
         chk(rts === (m_st != 0), "R6/R11", "rts", rts, m_st != 0);
         chk(ovf === m_ovf, "R3", "ovf", ovf, m_ovf);
         if (rts && !rts_d) rts_rises++;
         rts_d = rts;
         if (m_adv && rst_n) begin
            rx.push_back(txd);
            if (rx.size() == 10) begin
               int val;
               val = 0;
               for (int i = 0; i < 8; i++) val |= int'(rx[1+i]) << i;
               chk(rx[0] == 1'b0, "R5", "start bit", rx[0], 0);
               chk(rx[9] == 1'b1, "R5", "stop bit", rx[9], 1);
               if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected frame", val, -1);
               else begin
                  int e;
                  string t;
                  e = exp_q.pop_front(); t = tag_q.pop_front();
                  chk(val == e, t, "frame value", val, e);
               end
               rx.delete();
            end
         end
      end
   end

   always @(negedge clk) begin
      #1;
      sh_div = (sh_div == 3) ? 0 : sh_div + 1;
      if (sh_div == 0) shclk = ~shclk;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         report();
         $finish;
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic window(int n, int v, string tag);
      gate = 1'b1;
      repeat (4) step();
      repeat (n) begin
         sens = 1'b1; step(); step();
         sens = 1'b0; step(); step();
      end
      repeat (4) step();
      gate = 1'b0;
      if (v >= 0) begin exp_q.push_back(v); tag_q.push_back(tag); end
   endtask

   initial begin
      int r0;
      repeat (3) step();
      chk(txd === 1'b1, "R1", "txd in reset", txd, 1);
      chk(rts === 1'b0, "R1", "rts in reset", rts, 0);
      chk(ovf === 1'b0, "R1", "ovf in reset", ovf, 0);
      rst_n = 1'b1;
      repeat (5) step();
      chk(txd === 1'b1 && rts === 1'b0, "R1", "idle after reset", {txd, rts}, 2);
      cts = 1'b1;

      window(37, 37, "R2");
      repeat (200) step();
      window(0, 0, "R4");
      repeat (200) step();
      window(300, 255, "R3");
      repeat (200) step();
      chk(ovf === 1'b1, "R3", "ovf after saturation", ovf, 1);

      cts = 1'b0;
      window(5, 5, "R4");
      repeat (150) step();
      chk(rts === 1'b1, "R7", "rts held without cts", rts, 1);
      chk(txd === 1'b1, "R7", "txd held without cts", txd, 1);
      cts = 1'b1;
      repeat (200) step();
      chk(ovf === 1'b1, "R3", "ovf still set", ovf, 1);

      window(9, 9, "R8");
      while (m_st != 2) step();
      repeat (10) step();
      cts = 1'b0;
      repeat (200) step();
      chk(rts === 1'b0, "R8", "frame finished with cts low", rts, 0);
      cts = 1'b1;

      r0 = rts_rises;
      window(10, 10, "R9");
      repeat (20) step();
      window(3, -1, "");
      repeat (250) step();
      chk(rts_rises - r0 == 1, "R9", "captures in busy window", rts_rises - r0, 1);

      repeat (6) begin
         sens = 1'b1; step(); step();
         sens = 1'b0; step(); step();
      end
      window(4, 4, "R2");
      repeat (200) step();

      window(7, -1, "");
      while (m_st != 2) step();
      repeat (20) step();
      rst_n = 1'b0;
      repeat (3) step();
      chk(ovf === 1'b0, "R1", "ovf cleared by reset", ovf, 0);
      chk(rts === 1'b0, "R1", "frame abandoned", rts, 0);
      chk(txd === 1'b1, "R1", "txd after mid-frame reset", txd, 1);
      rst_n = 1'b1;
      repeat (10) step();
      window(2, 2, "R1");
      repeat (200) step();
      chk(exp_q.size() == 0, "R9", "frames outstanding", exp_q.size(), 0);

      done = 1'b1;
      report();
      $finish;
   end
endmodule